// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and date as packed BCD counters: seconds, minutes, hours, weekday, day of month, month, a two-digit year and, optionally, a century byte. A binary sub-second counter advances on a single-cycle tick enable that stands in for the oscillator prescaler. Each time it wraps, a one-second step ripples up the calendar. Day-of-month wrap follows month length, including the leap-year February.

Software loads and reads every counter through a byte-wide register port. The read data is a combinational function of the address. Two control registers carry the run gates, a prescaler clear, a 30-second rounding command, and a carry flag. The flag is raised on every one-second step, so software that reads the time across several registers can tell when its read may have been torn and retry it. A carry interrupt output follows the flag when the flag's enable is set.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset, seconds, minutes, hours, weekday and year read 00, day and month read 01, the century reads 0x20, both control registers read 0x00, and `carry_irq_o` is 0.
- R2: The registers sit at these indices: 0 sub-second, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day, 6 month, 7 year within century, 8 century, 14 control A, 15 control B. A write stores its byte in the cycle it occurs, with no BCD correction, and takes precedence over any count in that same cycle.
- R3: The sub-second counter (6 bits, read zero-extended) advances by one per `tick_i` only while both start (control B bit 0) and enable (control B bit 3) are 1, so its top bit (value 0x20) marks the half-second. A tick at 63 wraps the counter to 0 and makes a one-second step.
- R4: Seconds and minutes wrap from 59 to 00, and hours wrap from 23 to 00. Each wrap carries into the next field. Within a field, the units digit carries into the tens digit after 9.
- R5: The weekday advances with every day step and wraps from 6 to 0.
- R6: The day wraps to 01 after 31 in months 01, 03, 05, 07, 08, 10 and 12, and after 30 in months 04, 06, 09 and 11. In February it wraps after 28, or after 29 when the BCD year within the century is a multiple of 4.
- R7: The month wraps from 12 to 01 with a carry into the year. The year wraps from 99 to 00 with a carry into the century.
- R8: The carry flag (control A bit 7) is set by every one-second step. Writing 0 to that bit clears it and writing 1 leaves it unchanged. A set and a clear in the same cycle leave the flag set.
- R9: `carry_irq_o` is 1 exactly when the carry flag and the carry interrupt enable (control A bit 4) are both 1.
- R10: Writing 1 to control B bit 1 clears the sub-second counter. The bit always reads back 0.
- R11: Writing 1 to control B bit 2 clears the seconds and the sub-second counter. If the seconds were 30 or more, the minute field also advances, with ripple, and the carry flag is set. The bit always reads back 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescaler tick enable, one cycle per sub-second step |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register index for both read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the register at `addr_i` |
| carry_irq_o | output | 1 | Carry interrupt request |

## Verification
The counting assertions assume that `tick_i` is a one-cycle qualifier and that a cycle carrying a register write is a cycle in which software may override any count. For that reason, the halt and sub-second-step properties are gated off whenever `wr_i` is high. The stimulus raises `tick_i` only in cycles without a write, except in two deliberate cases: one checks that a load beats a count, and one checks that a flag set beats a flag clear. Both cases are checked directly at the read port.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W = 8;

  localparam int IDX_SUB  = 0;
  localparam int IDX_SEC  = 1;
  localparam int IDX_MIN  = 2;
  localparam int IDX_HR   = 3;
  localparam int IDX_WK   = 4;
  localparam int IDX_DAY  = 5;
  localparam int IDX_MON  = 6;
  localparam int IDX_YR   = 7;
  localparam int IDX_CEN  = 8;
  localparam int IDX_CTLA = 14;
  localparam int IDX_CTLB = 15;

  localparam int CF_BIT    = 7;
  localparam int CIE_BIT   = 4;
  localparam int EN_BIT    = 3;
  localparam int ADJ_BIT   = 2;
  localparam int PRST_BIT  = 1;
  localparam int START_BIT = 0;

  typedef logic [BYTE_W-1:0] bcd8_t;

  function automatic bcd8_t bcd_inc(input bcd8_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // multiple of 4 in BCD: even tens with units 0/4/8, odd tens with units 2/6
  function automatic logic bcd_leap(input bcd8_t y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction
endpackage

// File: rtl/rtc_month_len.sv
module rtc_month_len import rtc_pkg::*; (
  input  bcd8_t month_i,
  input  bcd8_t year_i,
  output bcd8_t last_day_o
);
  always_comb begin
    case (month_i)
      8'h02:                      last_day_o = bcd_leap(year_i) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day_o = 8'h30;
      default:                    last_day_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field import rtc_pkg::*; #(
  parameter bcd8_t RST_VAL = '0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  bcd8_t load_val_i,
  input  logic  clr_i,
  input  logic  inc_i,
  input  bcd8_t lo_i,
  input  bcd8_t hi_i,
  output bcd8_t val_o,
  output logic  wrap_o
);
  bcd8_t val_q;

  // >= so an out-of-range load still wraps on the next step
  assign wrap_o = inc_i && (val_q >= hi_i);
  assign val_o  = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= RST_VAL;
    else if (load_i) val_q <= load_val_i;
    else if (clr_i)  val_q <= '0;
    else if (inc_i)  val_q <= wrap_o ? lo_i : bcd_inc(val_q);
  end

  a_r4_wrap_to_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && !load_i && !clr_i) |=> (val_o == $past(lo_i)));
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar import rtc_pkg::*; #(
  parameter int SUB_W  = 6,
  parameter bit YEAR4  = 1'b1,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              carry_irq_o
);
  localparam logic [SUB_W-1:0] SUB_MAX = '1;

  logic [SUB_W-1:0] sub_q;
  logic cf_q, cie_q, en_q, start_q;
  bcd8_t sec_q, min_q, hr_q, wk_q, day_q, mon_q, yr_q, cen_q, last_day;
  logic sec_wrap, min_wrap, hr_wrap, wk_wrap, day_wrap, mon_wrap, yr_wrap, cen_wrap;

  function automatic logic hit(input int idx);
    return wr_i && (addr_i == ADDR_W'(idx));
  endfunction

  logic wr_ctla, wr_ctlb, adj, pre_clr, run, sec_step, adj_carry, cf_set;
  assign wr_ctla   = hit(IDX_CTLA);
  assign wr_ctlb   = hit(IDX_CTLB);
  assign adj       = wr_ctlb && wdata_i[ADJ_BIT];
  assign pre_clr   = wr_ctlb && wdata_i[PRST_BIT];
  assign run       = start_q && en_q;
  assign sec_step  = run && tick_i && (sub_q == SUB_MAX);
  assign adj_carry = adj && (sec_q >= 8'h30);
  assign cf_set    = sec_step || adj_carry;

  // control registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cf_q <= 1'b0; cie_q <= 1'b0; en_q <= 1'b0; start_q <= 1'b0;
    end else begin
      cf_q <= cf_set || (cf_q && !(wr_ctla && !wdata_i[CF_BIT]));
      if (wr_ctla) cie_q <= wdata_i[CIE_BIT];
      if (wr_ctlb) begin
        en_q    <= wdata_i[EN_BIT];
        start_q <= wdata_i[START_BIT];
      end
    end
  end

  // sub-second counter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sub_q <= '0;
    else if (hit(IDX_SUB))       sub_q <= wdata_i[SUB_W-1:0];
    else if (pre_clr || adj)     sub_q <= '0;
    else if (run && tick_i)      sub_q <= sub_q + SUB_W'(1);
  end

  rtc_month_len u_mlen (.month_i(mon_q), .year_i(yr_q), .last_day_o(last_day));

  rtc_bcd_field #(.RST_VAL(8'h00)) u_sec (.clk_i, .rst_ni, .load_i(hit(IDX_SEC)), .load_val_i(wdata_i),
    .clr_i(adj), .inc_i(sec_step), .lo_i(8'h00), .hi_i(8'h59), .val_o(sec_q), .wrap_o(sec_wrap));
  rtc_bcd_field #(.RST_VAL(8'h00)) u_min (.clk_i, .rst_ni, .load_i(hit(IDX_MIN)), .load_val_i(wdata_i),
    .clr_i(1'b0), .inc_i(sec_wrap || adj_carry), .lo_i(8'h00), .hi_i(8'h59), .val_o(min_q), .wrap_o(min_wrap));
  rtc_bcd_field #(.RST_VAL(8'h00)) u_hr (.clk_i, .rst_ni, .load_i(hit(IDX_HR)), .load_val_i(wdata_i),
    .clr_i(1'b0), .inc_i(min_wrap), .lo_i(8'h00), .hi_i(8'h23), .val_o(hr_q), .wrap_o(hr_wrap));
  rtc_bcd_field #(.RST_VAL(8'h00)) u_wk (.clk_i, .rst_ni, .load_i(hit(IDX_WK)), .load_val_i(wdata_i),
    .clr_i(1'b0), .inc_i(hr_wrap), .lo_i(8'h00), .hi_i(8'h06), .val_o(wk_q), .wrap_o(wk_wrap));
  rtc_bcd_field #(.RST_VAL(8'h01)) u_day (.clk_i, .rst_ni, .load_i(hit(IDX_DAY)), .load_val_i(wdata_i),
    .clr_i(1'b0), .inc_i(hr_wrap), .lo_i(8'h01), .hi_i(last_day), .val_o(day_q), .wrap_o(day_wrap));
  rtc_bcd_field #(.RST_VAL(8'h01)) u_mon (.clk_i, .rst_ni, .load_i(hit(IDX_MON)), .load_val_i(wdata_i),
    .clr_i(1'b0), .inc_i(day_wrap), .lo_i(8'h01), .hi_i(8'h12), .val_o(mon_q), .wrap_o(mon_wrap));
  rtc_bcd_field #(.RST_VAL(8'h00)) u_yr (.clk_i, .rst_ni, .load_i(hit(IDX_YR)), .load_val_i(wdata_i),
    .clr_i(1'b0), .inc_i(mon_wrap), .lo_i(8'h00), .hi_i(8'h99), .val_o(yr_q), .wrap_o(yr_wrap));

  generate
    if (YEAR4) begin : g_century
      rtc_bcd_field #(.RST_VAL(8'h20)) u_cen (.clk_i, .rst_ni, .load_i(hit(IDX_CEN)), .load_val_i(wdata_i),
        .clr_i(1'b0), .inc_i(yr_wrap), .lo_i(8'h00), .hi_i(8'h99), .val_o(cen_q), .wrap_o(cen_wrap));
    end else begin : g_no_century
      assign cen_q    = '0;
      assign cen_wrap = 1'b0;
    end
  endgenerate

  logic unused_wrap;
  assign unused_wrap = ^{wk_wrap, yr_wrap, cen_wrap};

  always_comb begin
    case (addr_i)
      ADDR_W'(IDX_SUB):  rdata_o = BYTE_W'(sub_q);
      ADDR_W'(IDX_SEC):  rdata_o = sec_q;
      ADDR_W'(IDX_MIN):  rdata_o = min_q;
      ADDR_W'(IDX_HR):   rdata_o = hr_q;
      ADDR_W'(IDX_WK):   rdata_o = wk_q;
      ADDR_W'(IDX_DAY):  rdata_o = day_q;
      ADDR_W'(IDX_MON):  rdata_o = mon_q;
      ADDR_W'(IDX_YR):   rdata_o = yr_q;
      ADDR_W'(IDX_CEN):  rdata_o = cen_q;
      ADDR_W'(IDX_CTLA): rdata_o = {cf_q, 2'b00, cie_q, 4'b0000};
      ADDR_W'(IDX_CTLB): rdata_o = {4'b0000, en_q, 2'b00, start_q};
      default:           rdata_o = '0;
    endcase
  end

  assign carry_irq_o = cf_q && cie_q;

  a_r8_flag_on_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_step |=> cf_q);
  a_r3_halt_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !wr_i) |=> ($stable(sub_q) && $stable(sec_q)));
  a_r3_sub_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && tick_i && !wr_i) |=> (sub_q == SUB_W'($past(sub_q) + 1'b1)));
  a_r10_prescale_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctlb && wdata_i[PRST_BIT] && !hit(IDX_SUB)) |=> (sub_q == '0));
endmodule

// File: tb/tb_rtc_bcd_calendar.sv
module tb_rtc_bcd_calendar;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       irq;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  rtc_bcd_calendar dut (.clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr), .addr_i(addr),
                        .wdata_i(wdata), .rdata_o(rdata), .carry_irq_o(irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin @(negedge clk); tick = 1'b1; end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic set_cal(input logic [7:0] s, mi, h, w, d, mo, y, c);
    wr_reg(1, s); wr_reg(2, mi); wr_reg(3, h); wr_reg(4, w);
    wr_reg(5, d); wr_reg(6, mo); wr_reg(7, y); wr_reg(8, c);
    wr_reg(0, 8'h3F);
  endtask

  task automatic t_reset;
    rd_chk("R1 sub", 0, 8'h00); rd_chk("R1 sec", 1, 8'h00); rd_chk("R1 min", 2, 8'h00);
    rd_chk("R1 hr", 3, 8'h00);  rd_chk("R1 wk", 4, 8'h00);  rd_chk("R1 day", 5, 8'h01);
    rd_chk("R1 mon", 6, 8'h01); rd_chk("R1 yr", 7, 8'h00);  rd_chk("R1 cen", 8, 8'h20);
    rd_chk("R1 ctla", 14, 8'h00); rd_chk("R1 ctlb", 15, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_map;
    wr_reg(1, 8'h7A); rd_chk("R2 non-BCD sec kept", 1, 8'h7A);
    wr_reg(4, 8'h05); rd_chk("R2 weekday load", 4, 8'h05);
    wr_reg(8, 8'h19); rd_chk("R2 century load", 8, 8'h19);
    wr_reg(7, 8'h42); rd_chk("R2 year load", 7, 8'h42);
    // load beats a count in the same cycle
    wr_reg(15, 8'h09); wr_reg(1, 8'h10); wr_reg(0, 8'h3F);
    @(negedge clk); wr = 1'b1; addr = 4'd1; wdata = 8'h40; tick = 1'b1;
    @(negedge clk); wr = 1'b0; tick = 1'b0;
    rd_chk("R2 load wins over step", 1, 8'h40);
    rd_chk("R2 sub still wrapped", 0, 8'h00);
  endtask

  task automatic t_run_gate;
    wr_reg(15, 8'h00); wr_reg(0, 8'h05); ticks(10);
    rd_chk("R3 stopped", 0, 8'h05);
    wr_reg(15, 8'h01); ticks(10);
    rd_chk("R3 start without enable", 0, 8'h05);
    wr_reg(15, 8'h09); ticks(10);
    rd_chk("R3 running", 0, 8'h0F);
    wr_reg(0, 8'h1F); ticks(1);
    rd_chk("R3 half-second bit", 0, 8'h20);
    wr_reg(1, 8'h09); wr_reg(2, 8'h33); wr_reg(0, 8'h3E); ticks(2);
    rd_chk("R3 R4 digit carry", 1, 8'h10);
    rd_chk("R4 minute untouched", 2, 8'h33);
  endtask

  task automatic t_rollover;
    wr_reg(15, 8'h09);
    set_cal(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99, 8'h20);
    ticks(1);
    rd_chk("R4 sec wrap", 1, 8'h00); rd_chk("R4 min wrap", 2, 8'h00);
    rd_chk("R4 hr wrap", 3, 8'h00);  rd_chk("R5 weekday wrap", 4, 8'h00);
    rd_chk("R6 day wrap", 5, 8'h01); rd_chk("R7 month wrap", 6, 8'h01);
    rd_chk("R7 year wrap", 7, 8'h00); rd_chk("R7 century step", 8, 8'h21);
    set_cal(8'h59, 8'h59, 8'h23, 8'h02, 8'h10, 8'h05, 8'h23, 8'h20);
    ticks(1);
    rd_chk("R5 weekday step", 4, 8'h03);
    rd_chk("R6 plain day step", 5, 8'h11);
  endtask

  task automatic one_day(input string req, input logic [7:0] d, mo, y, ed, emo);
    set_cal(8'h59, 8'h59, 8'h23, 8'h00, d, mo, y, 8'h20);
    ticks(1);
    rd_chk(req, 5, ed);
    rd_chk(req, 6, emo);
  endtask

  task automatic t_month_len;
    wr_reg(15, 8'h09);
    one_day("R6 30-day month", 8'h30, 8'h04, 8'h23, 8'h01, 8'h05);
    one_day("R6 31-day Jan",   8'h31, 8'h01, 8'h23, 8'h01, 8'h02);
    one_day("R6 Nov 30",       8'h30, 8'h11, 8'h23, 8'h01, 8'h12);
    one_day("R6 Feb common",   8'h28, 8'h02, 8'h23, 8'h01, 8'h03);
    one_day("R6 Feb leap 24",  8'h28, 8'h02, 8'h24, 8'h29, 8'h02);
    one_day("R6 Feb 29 end",   8'h29, 8'h02, 8'h24, 8'h01, 8'h03);
    one_day("R6 Feb leap 12",  8'h28, 8'h02, 8'h12, 8'h29, 8'h02);
    one_day("R6 Feb common 10", 8'h28, 8'h02, 8'h10, 8'h01, 8'h03);
  endtask

  task automatic t_flag;
    wr_reg(15, 8'h09); wr_reg(14, 8'h00);
    rd_chk("R8 cleared", 14, 8'h00);
    wr_reg(0, 8'h3F); ticks(1);
    rd_chk("R8 set by step", 14, 8'h80);
    chk("R9 irq masked", {7'b0, irq}, 8'h00);
    wr_reg(14, 8'h90);
    rd_chk("R8 write 1 keeps", 14, 8'h90);
    chk("R9 irq raised", {7'b0, irq}, 8'h01);
    wr_reg(14, 8'h10);
    rd_chk("R8 write 0 clears", 14, 8'h10);
    chk("R9 irq dropped", {7'b0, irq}, 8'h00);
    wr_reg(0, 8'h3F);
    @(negedge clk); wr = 1'b1; addr = 4'd14; wdata = 8'h10; tick = 1'b1;
    @(negedge clk); wr = 1'b0; tick = 1'b0;
    rd_chk("R8 set beats clear", 14, 8'h90);
    wr_reg(14, 8'h00);
  endtask

  task automatic t_prescale_reset;
    wr_reg(15, 8'h09); wr_reg(1, 8'h17); wr_reg(0, 8'h25);
    wr_reg(15, 8'h0B);
    rd_chk("R10 sub cleared", 0, 8'h00);
    rd_chk("R10 bit reads 0", 15, 8'h09);
    rd_chk("R10 seconds kept", 1, 8'h17);
  endtask

  task automatic t_adjust;
    wr_reg(15, 8'h09);
    wr_reg(1, 8'h45); wr_reg(2, 8'h59); wr_reg(3, 8'h10); wr_reg(0, 8'h11);
    wr_reg(14, 8'h00);
    wr_reg(15, 8'h0D);
    rd_chk("R11 sec cleared", 1, 8'h00); rd_chk("R11 min carry wrap", 2, 8'h00);
    rd_chk("R11 hr ripple", 3, 8'h11);   rd_chk("R11 sub cleared", 0, 8'h00);
    rd_chk("R11 bit reads 0", 15, 8'h09); rd_chk("R11 flag set", 14, 8'h80);
    wr_reg(1, 8'h29); wr_reg(2, 8'h12); wr_reg(14, 8'h00);
    wr_reg(15, 8'h0D);
    rd_chk("R11 round down sec", 1, 8'h00);
    rd_chk("R11 round down min", 2, 8'h12);
    rd_chk("R11 no flag", 14, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_run_gate();
    t_rollover();
    t_month_len();
    t_flag();
    t_prescale_reset();
    t_adjust();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule